// File: doc/BRIEF.md
# GPIO Port with Input-Change Interrupt

This block is an eight-pin bidirectional general-purpose I/O port that sits on a simple synchronous register bus. Software sets each pin's direction, writes output values into a latch, reads pin levels back, and controls one shared weak pull-up switch. For each pin the block drives an output-enable, an output value and a pull-up enable.

The four upper pins can raise an interrupt when their level changes. When software reads or writes the port register, the block takes a snapshot of those pins. Any upper pin that is an input and now differs from its snapshot sets a sticky change flag. The flag is set again on every cycle while the difference remains. Software therefore clears the mismatch with a port access first, and only then clears the flag.

Bus map (2-bit address): 0 = port, 1 = output latch, 2 = direction, 3 = control. In the control register, bit 0 is the change flag, bit 1 is the interrupt enable and bit 2 is the pull-up disable. The other control bits read as zero. A read's data appears on `bus_rdata` one clock after the read strobe.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset the direction register reads all ones, the latch reads zero, and the control register reads 0x04. That value means pull-ups off, interrupt disabled and flag clear. `pin_oe`, `pin_out`, `pin_pu` and `irq` are all zero.
- R2: Direction bit 1 makes the pin an input, so `pin_oe` is 0 for that pin. Direction bit 0 makes it an output: `pin_oe` is 1 and `pin_out` carries the latch bit.
- R3: A write to address 1 or to address 0 loads the output latch. A read of address 1 returns the latch contents, not the pin levels.
- R4: A read of address 0 returns the pin levels after a two-flop synchronizer. A pin change driven in the same cycle as a read is not yet visible in that read's data.
- R5: When control bit 2 is 0, every input pin has its pull-up enabled. When control bit 2 is 1, no pin has a pull-up. A pin set as an output never has a pull-up.
- R6: Only pins 7..4 that are inputs take part in change detection. Changes on pins 3..0, or on upper pins set as outputs, never set the flag.
- R7: The flag (control bit 0) is set once any participating pin differs from the snapshot taken at the last port read or write. The flag then shows on a control read.
- R8: A port read refreshes the snapshot and ends the mismatch, and a port write does the same. After that, writing 0 to control bit 0 clears the flag. Writing 1 to that bit never sets it.
- R9: While a mismatch persists, writing 0 to control bit 0 leaves the flag set.
- R10: `irq` equals the flag ANDed with the interrupt enable (control bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after the strobe |
| pin_in | input | 8 | Pin levels from the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| irq | output | 1 | Change interrupt request |

## Verification
A snapshot register that held stale or wrong bits would show up as a false or missing `irq`. This would appear three clocks after a pin change and would stay visible after software tried to clear the flag. A flag whose set/clear priority was inverted would read back clear during a persistent mismatch on the next control read. A latch, direction or pull-up fault appears at the pin outputs on the clock after the register write. A synchronizer of the wrong depth changes which port read first sees a new pin level.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    A_PORT = 2'd0,
    A_LAT  = 2'd1,
    A_DIR  = 2'd2,
    A_CTRL = 2'd3
  } gpio_addr_e;

  localparam int CTRL_FLAG  = 0;
  localparam int CTRL_IE    = 1;
  localparam int CTRL_PUOFF = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sync_hi,
  input  logic [N-1:0] dir_hi,
  input  logic         access,
  input  logic         clr_wr,
  input  logic         clr_val,
  output logic         flag
);
  logic [N-1:0] snap;
  logic [N-1:0] diff;
  logic         mismatch;

  assign diff     = (sync_hi ^ snap) & dir_hi;
  assign mismatch = |diff;

  always_ff @(posedge clk) begin
    if (rst) snap <= '0;
    else if (access) snap <= sync_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else if (mismatch) flag <= 1'b1;
    else if (clr_wr && !clr_val) flag <= 1'b0;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> flag);                                          // R7
  AST_FLAG_PERSIST: assert property (@(posedge clk) disable iff (rst)
    (mismatch && clr_wr && !clr_val) |=> flag);                  // R9
  AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    access |=> (snap == $past(sync_hi)));                        // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!flag && ((sync_hi ^ snap) & dir_hi) == '0) |=> !flag);     // R6
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_pkg::*;
#(
  parameter int W           = 8,
  parameter int CHG_LO      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_pu,
  output logic         irq
);
  localparam int NCHG = W - CHG_LO;

  logic [W-1:0] dir_q, lat_q, pin_s;
  logic         ie_q, puoff_q, flag;
  logic         sel_port, sel_lat, sel_dir, sel_ctrl, port_access;

  assign sel_port    = (bus_addr == A_PORT);
  assign sel_lat     = (bus_addr == A_LAT);
  assign sel_dir     = (bus_addr == A_DIR);
  assign sel_ctrl    = (bus_addr == A_CTRL);
  assign port_access = sel_port && (bus_wr || bus_rd);

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  gpio_chg_detect #(.N(NCHG)) u_chg (
    .clk     (clk),
    .rst     (rst),
    .sync_hi (pin_s[W-1:CHG_LO]),
    .dir_hi  (dir_q[W-1:CHG_LO]),
    .access  (port_access),
    .clr_wr  (bus_wr && sel_ctrl),
    .clr_val (bus_wdata[CTRL_FLAG]),
    .flag    (flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '1;
      lat_q   <= '0;
      ie_q    <= 1'b0;
      puoff_q <= 1'b1;
    end else if (bus_wr) begin
      if (sel_port || sel_lat) lat_q <= bus_wdata;
      if (sel_dir) dir_q <= bus_wdata;
      if (sel_ctrl) begin
        ie_q    <= bus_wdata[CTRL_IE];
        puoff_q <= bus_wdata[CTRL_PUOFF];
      end
    end
  end

  logic [W-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[CTRL_FLAG]  = flag;
    ctrl_rd[CTRL_IE]    = ie_q;
    ctrl_rd[CTRL_PUOFF] = puoff_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      unique case (bus_addr)
        A_PORT:  bus_rdata <= pin_s;
        A_LAT:   bus_rdata <= lat_q;
        A_DIR:   bus_rdata <= dir_q;
        default: bus_rdata <= ctrl_rd;
      endcase
    end
  end

  assign pin_oe  = ~dir_q;
  assign pin_out = lat_q;
  assign pin_pu  = dir_q & {W{~puoff_q}};
  assign irq     = flag & ie_q;

  AST_LAT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (sel_port || sel_lat)) |=> (pin_out == $past(bus_wdata))); // R3
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_dir) |=> (pin_oe == ~$past(bus_wdata)));               // R2
endmodule

// File: tb/gpio_chg_port_bench.sv
module gpio_chg_port_bench;
  import gpio_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pin_in = '0, pin_oe, pin_out, pin_pu;
  logic       irq;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  gpio_chg_port u_gpio_chg_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_pu(input logic [7:0] dir, input logic puoff);
    return puoff ? 8'h00 : dir;
  endfunction

  function automatic logic exp_mism(input logic [7:0] a, input logic [7:0] b,
                                    input logic [7:0] dir);
    return |((a[7:4] ^ b[7:4]) & dir[7:4]);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    logic [7:0] rd, d, l, p0, p1;
    logic       po, e;
    void'($urandom(32'h1234_5678));
    waitn(5);
    rst = 1'b0;
    waitn(1);

    // R1 reset state
    chk(pin_oe == 8'h00, "R1 pin_oe", pin_oe, 0);
    chk(pin_out == 8'h00, "R1 pin_out", pin_out, 0);
    chk(pin_pu == 8'h00, "R1 pin_pu", pin_pu, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    brd(A_DIR, rd);  chk(rd == 8'hFF, "R1 dir", rd, 8'hFF);
    brd(A_LAT, rd);  chk(rd == 8'h00, "R1 latch", rd, 0);
    brd(A_CTRL, rd); chk(rd == 8'h04, "R1 ctrl", rd, 4);

    // R2 R3 R5 random direction / latch / pull-up
    for (int i = 0; i < 24; i++) begin
      d = 8'($urandom); l = 8'($urandom); po = 1'($urandom);
      pin_in = 8'($urandom);
      bwr(A_DIR, d); bwr(A_LAT, l); bwr(A_CTRL, {5'b0, po, 2'b00});
      chk(pin_oe == ~d, "R2 oe", pin_oe, ~d);
      chk((pin_out & ~d) == (l & ~d), "R2 out", pin_out & ~d, l & ~d);
      chk(pin_pu == exp_pu(d, po), "R5 pu", pin_pu, exp_pu(d, po));
      brd(A_LAT, rd); chk(rd == l, "R3 latch read", rd, l);
    end
    bwr(A_DIR, 8'h00); bwr(A_CTRL, 8'h00);
    chk(pin_pu == 8'h00, "R5 outputs no pu", pin_pu, 0);
    bwr(A_DIR, 8'hFF);
    chk(pin_pu == 8'hFF, "R5 inputs pu on", pin_pu, 8'hFF);
    bwr(A_CTRL, 8'h04);

    // R3 port write loads latch
    bwr(A_PORT, 8'hA5);
    brd(A_LAT, rd); chk(rd == 8'hA5, "R3 port write", rd, 8'hA5);
    chk(pin_out == 8'hA5, "R3 pin_out", pin_out, 8'hA5);

    // R4 synchronized port read
    pin_in = 8'h3C; waitn(4);
    brd(A_PORT, rd); chk(rd == 8'h3C, "R4 port read", rd, 8'h3C);
    pin_in = 8'hC3;
    brd(A_PORT, rd); chk(rd == 8'h3C, "R4 sync delay", rd, 8'h3C);
    waitn(3);
    brd(A_PORT, rd); chk(rd == 8'hC3, "R4 settled", rd, 8'hC3);
    bwr(A_CTRL, 8'h04); waitn(2);

    // R6 directed: lower pins and output pins ignored
    bwr(A_DIR, 8'hFF); brd(A_PORT, rd); bwr(A_CTRL, 8'h06);
    pin_in = pin_in ^ 8'h0F; waitn(4);
    chk(irq == 1'b0, "R6 low pins", irq, 0);
    bwr(A_DIR, 8'h0F); brd(A_PORT, rd); bwr(A_CTRL, 8'h06);
    pin_in = pin_in ^ 8'hF0; waitn(4);
    brd(A_CTRL, rd); chk(rd[0] == 1'b0, "R6 output pins", rd[0], 0);

    // R8 write of 1 does not set flag
    bwr(A_CTRL, 8'h07); waitn(1);
    brd(A_CTRL, rd); chk(rd[0] == 1'b0, "R8 write one", rd[0], 0);

    // R10 enable gating
    bwr(A_DIR, 8'hFF); brd(A_PORT, rd); bwr(A_CTRL, 8'h04);
    pin_in = pin_in ^ 8'h80; waitn(4);
    chk(irq == 1'b0, "R10 masked", irq, 0);
    brd(A_CTRL, rd); chk(rd[0] == 1'b1, "R10 flag raw", rd[0], 1);
    bwr(A_CTRL, 8'h06); waitn(1);
    chk(irq == 1'b1, "R10 enabled", irq, 1);
    brd(A_PORT, rd); bwr(A_CTRL, 8'h06); waitn(2);

    // R7 R8 R9 R10 random change sequences
    for (int i = 0; i < 40; i++) begin
      d = 8'($urandom); p0 = 8'($urandom); p1 = 8'($urandom);
      if (i % 4 == 0) p1 = p0 ^ 8'h40;
      bwr(A_DIR, d); pin_in = p0; waitn(4);
      brd(A_PORT, rd); bwr(A_CTRL, 8'h06); waitn(3);
      chk(irq == 1'b0, "R8 clean start", irq, 0);
      pin_in = p1; waitn(4);
      e = exp_mism(p0, p1, d);
      chk(irq == e, "R7 change irq", irq, e);
      bwr(A_CTRL, 8'h06); waitn(2);
      brd(A_CTRL, rd); chk(rd[0] == e, "R9 persist", rd[0], e);
      brd(A_PORT, rd); bwr(A_CTRL, 8'h06); waitn(2);
      chk(irq == 1'b0, "R8 cleared", irq, 0);
    end

    waitn(2);
    finish_run();
  end
endmodule